// File: doc/BRIEF.md
# Programmable-Priority Interrupt Controller

This block arbitrates among thirteen level-sensitive interrupt sources, numbered 1 to 13, and presents one request to the CPU. The request is a 3-bit priority level and an 8-bit exception vector. Each source has an 8-bit control register with three fields. A 5-bit rank in bits 4:0 decides arbitration. The level comes from bits 4:2. Bit 7 selects an automatic vector. A 13-bit mask register blocks individual sources. The live request state can be read back from a pending register.

Each cycle the controller takes the sources that are pending and not masked, and picks the one with the highest rank. The lower source number wins a tie. If the winning rank is too low, nothing is presented. Otherwise the controller builds the vector in one of two ways. An automatic vector is a fixed base plus the level. A non-automatic vector comes from one of three vector registers, which belong to the watchdog source and the two serial-port sources. Software programs the controller through a simple byte-addressed write port with a combinational read port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the state is as follows. The mask register holds 0x3FFE, so every source is masked. The control registers of sources 1 to 13 hold 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x1C, 0x80, 0x80, 0x80, 0x00 and 0x00. The watchdog vector register holds 0x0F and both serial vector registers hold 0x00. The level and vector outputs are 0.
- R2: Pending bit i (offset 0x3A, bit i) copies input source i on every clock. Bits 0, 15 and 14 read 0. A write to 0x3A has no effect.
- R3: The mask register sits at offset 0x36. Bit i masks source i when it is 1. Bits 13:1 are writable and read back, and all other bits read 0.
- R4: The control register of source i sits at byte offset 0x14+(i-1). It takes write data bits 7:0 and reads back in bits 7:0. Any unmapped offset reads 0.
- R5: The active set is pending AND NOT mask. Among the active sources, the one with the largest control bits 4:0 wins, and on equal values the lower source number wins.
- R6: If no source is active, or the winning rank is below 4, the level and the vector are both 0.
- R7: A presented level equals the winner's control bits 4:2. When control bit 7 is 1, the vector is 24 plus that level.
- R8: When bit 7 is 0, the vector is taken as follows. Source 8 uses the watchdog vector register (offset 0x40). Source 12 uses serial vector A (0x41). Source 13 uses serial vector B (0x42). Any other source yields 0x0F.
- R9: The outputs are registered. A change on a source input shows on the outputs two clocks later, one clock for pending capture and one for the output register. A write to the mask or control registers shows on the outputs one clock after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | 13 | Source request levels, bit i = source i (bits 13:1) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i (combinational) |
| cpu_level_o | output | 3 | Presented interrupt level, 0 = none |
| cpu_vector_o | output | 8 | Presented exception vector |

## Verification
The hardest case to reach is one where arbitration is decided by a rule other than "highest rank wins". This covers equal ranks among several active sources, and a winner whose rank falls below 4 while other sources are also active. The reset control values give almost no ties, so the stimulus reprograms control registers to create them. One test gives two sources the same rank, one of them autovectored, so that the vector shows which source won. Another lowers every active rank below 4. A long pseudo-random phase then toggles inputs and rewrites control and mask registers, and a behavioural model is compared against the design on every clock.

// File: rtl/prio_ic_pkg.sv
package prio_ic_pkg;
  localparam int RANK_W       = 5;
  localparam int LVL_W        = 3;
  localparam int VEC_W        = 8;
  localparam int CTRL_W       = 8;
  localparam int AUTOVEC_BIT  = 7;
  localparam int AUTOVEC_BASE = 24;
  localparam int MIN_RANK     = 4;
  localparam int NUM_VREG     = 3;
  localparam logic [VEC_W-1:0] FALLBACK_VEC = 8'h0F;

  // reset value of a source's control register
  function automatic logic [CTRL_W-1:0] ctrl_rst(input int src);
    if (src <= 7)       return CTRL_W'(src * 4);
    else if (src == 8)  return 8'h1C;
    else if (src <= 11) return 8'h80;
    else                return 8'h00;
  endfunction

  // reset value of vector register k (0 = watchdog, 1/2 = serial ports)
  function automatic logic [VEC_W-1:0] vec_rst(input int k);
    return (k == 0) ? 8'h0F : 8'h00;
  endfunction
endpackage

// File: rtl/prio_ic_regs.sv
module prio_ic_regs
  import prio_ic_pkg::*;
#(
  parameter int NSRC      = 13,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int CTRL_BASE = 'h14,
  parameter int MASK_OFS  = 'h36,
  parameter int PEND_OFS  = 'h3A,
  parameter int VEC_BASE  = 'h40
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NSRC:1]                 src_i,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic [NSRC:1]                 pend_o,
  output logic [NSRC:1]                 mask_o,
  output logic [NSRC:1][CTRL_W-1:0]     ctrl_o,
  output logic [NUM_VREG-1:0][VEC_W-1:0] vreg_o
);
  logic [NSRC:1]                  pend_q, pend_d;
  logic [NSRC:1]                  mask_q, mask_d;
  logic                           mask_en;
  logic [NSRC:1][CTRL_W-1:0]      ctrl_q;
  logic [NUM_VREG-1:0][VEC_W-1:0] vreg_q;
  logic                           live_q;
  logic                           unused_wbits;

  assign unused_wbits = ^{wdata_i[DATA_W-1:NSRC+1], wdata_i[0]};

  // next state
  always_comb begin
    pend_d  = src_i;
    mask_en = wr_en_i && (addr_i == ADDR_W'(MASK_OFS));
    mask_d  = wdata_i[NSRC:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      live_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      live_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_en) mask_q <= mask_d;
  end

  for (genvar gi = 1; gi <= NSRC; gi++) begin : g_ctrl
    logic              en;
    logic [CTRL_W-1:0] nxt;
    assign en  = wr_en_i && (addr_i == ADDR_W'(CTRL_BASE + gi - 1));
    assign nxt = wdata_i[CTRL_W-1:0];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctrl_q[gi] <= ctrl_rst(gi);
      else if (en) ctrl_q[gi] <= nxt;
    end
  end

  for (genvar gk = 0; gk < NUM_VREG; gk++) begin : g_vreg
    logic             en;
    logic [VEC_W-1:0] nxt;
    assign en  = wr_en_i && (addr_i == ADDR_W'(VEC_BASE + gk));
    assign nxt = wdata_i[VEC_W-1:0];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  vreg_q[gk] <= vec_rst(gk);
      else if (en) vreg_q[gk] <= nxt;
    end
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(MASK_OFS)) rdata_o[NSRC:1] = mask_q;
    if (addr_i == ADDR_W'(PEND_OFS)) rdata_o[NSRC:1] = pend_q;
    for (int i = 1; i <= NSRC; i++)
      if (addr_i == ADDR_W'(CTRL_BASE + i - 1)) rdata_o[CTRL_W-1:0] = ctrl_q[i];
    for (int k = 0; k < NUM_VREG; k++)
      if (addr_i == ADDR_W'(VEC_BASE + k)) rdata_o[VEC_W-1:0] = vreg_q[k];
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign ctrl_o = ctrl_q;
  assign vreg_o = vreg_q;

  // R2
  pend_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (pend_q == $past(src_i)));
  // R3
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_W'(MASK_OFS)) |=> (mask_o == $past(wdata_i[NSRC:1])));
  // R2
  pend_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_W'(PEND_OFS) && live_q) |=> (pend_o == $past(src_i)));
endmodule

// File: rtl/prio_ic_arb.sv
module prio_ic_arb
  import prio_ic_pkg::*;
#(
  parameter int NSRC  = 13,
  parameter int IDX_W = $clog2(NSRC + 1)
) (
  input  logic [NSRC:1]             active_i,
  input  logic [NSRC:1][CTRL_W-1:0] ctrl_i,
  output logic                      present_o,
  output logic [IDX_W-1:0]          win_idx_o,
  output logic [CTRL_W-1:0]         win_ctrl_o
);
  logic [NSRC:0][RANK_W-1:0] best_rank;
  logic [NSRC:0][IDX_W-1:0]  best_idx;
  logic [NSRC:0][CTRL_W-1:0] best_ctrl;

  assign best_rank[0] = '0;
  assign best_idx[0]  = '0;
  assign best_ctrl[0] = '0;

  // linear chain from source 1 upward; strict compare keeps the lower index on ties
  for (genvar gi = 1; gi <= NSRC; gi++) begin : g_stage
    logic take;
    assign take = active_i[gi] && (ctrl_i[gi][RANK_W-1:0] > best_rank[gi-1]);
    assign best_rank[gi] = take ? ctrl_i[gi][RANK_W-1:0] : best_rank[gi-1];
    assign best_idx[gi]  = take ? IDX_W'(gi)             : best_idx[gi-1];
    assign best_ctrl[gi] = take ? ctrl_i[gi]             : best_ctrl[gi-1];
  end

  assign present_o  = (best_rank[NSRC] >= RANK_W'(MIN_RANK));
  assign win_idx_o  = best_idx[NSRC];
  assign win_ctrl_o = best_ctrl[NSRC];
endmodule

// File: rtl/prio_ic_out.sv
module prio_ic_out
  import prio_ic_pkg::*;
#(
  parameter int NSRC     = 13,
  parameter int IDX_W    = $clog2(NSRC + 1),
  parameter int WDOG_SRC = 8,
  parameter int SERA_SRC = 12,
  parameter int SERB_SRC = 13
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           present_i,
  input  logic [IDX_W-1:0]               win_idx_i,
  input  logic [CTRL_W-1:0]              win_ctrl_i,
  input  logic [NUM_VREG-1:0][VEC_W-1:0] vreg_i,
  output logic [LVL_W-1:0]               level_o,
  output logic [VEC_W-1:0]               vector_o
);
  logic [LVL_W-1:0] lvl_d, lvl_q;
  logic [VEC_W-1:0] vec_d, vec_q;
  logic [LVL_W-1:0] win_lvl;
  logic             unused_cbits;

  assign unused_cbits = ^{win_ctrl_i[6:5], win_ctrl_i[1:0]};
  assign win_lvl      = win_ctrl_i[4:2];

  always_comb begin
    lvl_d = '0;
    vec_d = '0;
    if (present_i) begin
      lvl_d = win_lvl;
      if (win_ctrl_i[AUTOVEC_BIT])
        vec_d = VEC_W'(AUTOVEC_BASE) + VEC_W'(win_lvl);
      else if (win_idx_i == IDX_W'(WDOG_SRC))
        vec_d = vreg_i[0];
      else if (win_idx_i == IDX_W'(SERA_SRC))
        vec_d = vreg_i[1];
      else if (win_idx_i == IDX_W'(SERB_SRC))
        vec_d = vreg_i[2];
      else
        vec_d = FALLBACK_VEC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      vec_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      vec_q <= vec_d;
    end
  end

  assign level_o  = lvl_q;
  assign vector_o = vec_q;

  // R6
  idle_vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o == '0) |-> (vector_o == '0));
  // R6
  present_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    present_i |-> (win_ctrl_i[RANK_W-1:0] >= RANK_W'(MIN_RANK)));
  // R7
  autovec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o != '0 && $past(win_ctrl_i[AUTOVEC_BIT]))
      |-> (vector_o == VEC_W'(AUTOVEC_BASE) + VEC_W'(level_o)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_ic_pkg::*;
#(
  parameter int NSRC   = 13,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC:1]     irq_src_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [LVL_W-1:0]  cpu_level_o,
  output logic [VEC_W-1:0]  cpu_vector_o
);
  localparam int IDX_W = $clog2(NSRC + 1);

  logic [NSRC:1]                  pend, mask, active;
  logic [NSRC:1][CTRL_W-1:0]      ctrl;
  logic [NUM_VREG-1:0][VEC_W-1:0] vreg;
  logic                           present;
  logic [IDX_W-1:0]               win_idx;
  logic [CTRL_W-1:0]              win_ctrl;

  prio_ic_regs #(.NSRC(NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .src_i(irq_src_i), .wr_en_i(reg_wr_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .pend_o(pend), .mask_o(mask), .ctrl_o(ctrl), .vreg_o(vreg)
  );

  assign active = pend & ~mask;

  prio_ic_arb #(.NSRC(NSRC), .IDX_W(IDX_W)) arb_i (
    .active_i(active), .ctrl_i(ctrl), .present_o(present),
    .win_idx_o(win_idx), .win_ctrl_o(win_ctrl)
  );

  prio_ic_out #(.NSRC(NSRC), .IDX_W(IDX_W)) out_i (
    .clk(clk), .rst_n(rst_n), .present_i(present), .win_idx_i(win_idx),
    .win_ctrl_i(win_ctrl), .vreg_i(vreg), .level_o(cpu_level_o),
    .vector_o(cpu_vector_o)
  );

  // R9
  level_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_level_o != '0) |-> $past(|active));
  // R5
  winner_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    present |-> (active[win_idx] == 1'b1));
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  localparam int NSRC = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:1] irq = '0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0]  lvl;
  logic [7:0]  vec;

  always #2 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_src_i(irq), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .cpu_level_o(lvl), .cpu_vector_o(vec)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  string phase   = "R1";
  bit    done    = 0;

  // behavioural reference state
  logic [7:0]  m_ctrl [1:13];
  logic [15:0] m_mask, m_pend;
  logic [7:0]  m_vec [0:2];
  logic [2:0]  e_lvl;
  logic [7:0]  e_vec;

  function automatic logic [7:0] rst_ctrl(int s);
    if (s <= 7) return 8'(s * 4);
    if (s == 8) return 8'h1C;
    if (s <= 11) return 8'h80;
    return 8'h00;
  endfunction

  function automatic logic [10:0] ref_eval();
    int best = 0;
    int w = 0;
    logic [2:0] l;
    logic [7:0] v;
    for (int i = 1; i <= 13; i++)
      if (m_pend[i] && !m_mask[i] && int'(m_ctrl[i][4:0]) > best) begin
        best = int'(m_ctrl[i][4:0]);
        w = i;
      end
    if (best < 4) return '0;
    l = m_ctrl[w][4:2];
    if (m_ctrl[w][7]) v = 8'(24 + int'(l));
    else if (w == 8)  v = m_vec[0];
    else if (w == 12) v = m_vec[1];
    else if (w == 13) v = m_vec[2];
    else              v = 8'h0F;
    return {l, v};
  endfunction

  function automatic logic [15:0] ref_read(logic [7:0] a);
    if (a >= 8'h14 && a <= 8'h20) return {8'h00, m_ctrl[int'(a) - 'h13]};
    if (a == 8'h36) return m_mask;
    if (a == 8'h3A) return m_pend;
    if (a >= 8'h40 && a <= 8'h42) return {8'h00, m_vec[int'(a) - 'h40]};
    return 16'h0000;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i <= 13; i++) m_ctrl[i] = rst_ctrl(i);
      m_mask = 16'h3FFE;
      m_pend = '0;
      m_vec[0] = 8'h0F; m_vec[1] = 8'h00; m_vec[2] = 8'h00;
      e_lvl = '0; e_vec = '0;
    end else begin
      {e_lvl, e_vec} = ref_eval();
      m_pend = {2'b00, irq, 1'b0};
      if (wr) begin
        if (addr >= 8'h14 && addr <= 8'h20) m_ctrl[int'(addr) - 'h13] = wdata[7:0];
        else if (addr == 8'h36) m_mask = wdata & 16'h3FFE;
        else if (addr >= 8'h40 && addr <= 8'h42) m_vec[int'(addr) - 'h40] = wdata[7:0];
      end
    end
  end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // clock-by-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(phase, {13'd0, lvl}, {13'd0, e_lvl}, "level vs model");
      check(phase, {8'd0, vec},  {8'd0, e_vec},  "vector vs model");
    end
  end

  task automatic wr_reg(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a);
    @(negedge clk);
    addr = a;
    #1;
    check(tag, rdata, ref_read(a), $sformatf("read 0x%h", a));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic out_chk(string tag, logic [2:0] el, logic [7:0] ev);
    check(tag, {13'd0, lvl}, {13'd0, el}, "level");
    check(tag, {8'd0, vec},  {8'd0, ev},  "vector");
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    idle(3);
    rst_n = 1'b1;
    // R1: reset state
    phase = "R1";
    @(negedge clk); #1;
    out_chk("R1", 3'd0, 8'h00);
    addr = 8'h36; #1;
    check("R1", rdata, 16'h3FFE, "mask reset");
    for (int i = 1; i <= 13; i++) rd_chk("R1", 8'(8'h13 + i));
    addr = 8'h40; #1; check("R1", rdata, 16'h000F, "watchdog vector reset");
    addr = 8'h41; #1; check("R1", rdata, 16'h0000, "serial A vector reset");

    // R3: unmask everything, readback
    phase = "R3";
    wr_reg(8'h36, 16'hFFFF); rd_chk("R3", 8'h36);
    wr_reg(8'h36, 16'h0000); rd_chk("R3", 8'h36);
    // R4: control readback and unmapped read
    phase = "R4";
    wr_reg(8'h1A, 16'hAB5C); rd_chk("R4", 8'h1A);
    wr_reg(8'h1A, 16'h001C); rd_chk("R4", 8'h1A);
    addr = 8'h37; #1; check("R4", rdata, 16'h0000, "unmapped read");

    // R2: pending capture, write ignored
    phase = "R2";
    @(negedge clk); irq = 13'h1555;
    idle(1); addr = 8'h3A; #1;
    check("R2", rdata, 16'h2AAA, "pending mirrors inputs");
    wr_reg(8'h3A, 16'h0000); addr = 8'h3A; #1;
    check("R2", rdata, 16'h2AAA, "pending write ignored");
    @(negedge clk); irq = '0; idle(3);

    // R9: two-clock latency from input to output (source 7: ctrl 0x1C)
    phase = "R9";
    @(negedge clk); irq = 13'h0040;
    @(negedge clk); #1; out_chk("R9", 3'd0, 8'h00);
    @(negedge clk); #1; out_chk("R9", 3'd7, 8'h0F);
    @(negedge clk); irq = '0; idle(3);

    // R5: tie between source 3 (0x10) and source 5 (0x90 autovectored)
    phase = "R5";
    wr_reg(8'h16, 16'h0010); wr_reg(8'h18, 16'h0090);
    @(negedge clk); irq = 13'h0014;
    idle(2); out_chk("R5", 3'd4, 8'h0F);
    wr_reg(8'h18, 16'h0094); idle(1); out_chk("R5", 3'd5, 8'd29);

    // R6: ranks below 4 suppress
    phase = "R6";
    wr_reg(8'h16, 16'h0003); wr_reg(8'h18, 16'h0002);
    idle(1); out_chk("R6", 3'd0, 8'h00);
    @(negedge clk); irq = 13'h0100; // source 9, reset-like 0x80 rank 0
    wr_reg(8'h1C, 16'h0080); idle(2); out_chk("R6", 3'd0, 8'h00);

    // R7: autovector on source 9
    phase = "R7";
    wr_reg(8'h1C, 16'h0094); idle(1); out_chk("R7", 3'd5, 8'd29);
    @(negedge clk); irq = '0; idle(2);

    // R8: dedicated vector registers
    phase = "R8";
    wr_reg(8'h40, 16'h0041); wr_reg(8'h41, 16'h0052); wr_reg(8'h42, 16'h0063);
    wr_reg(8'h1B, 16'h0018); wr_reg(8'h1F, 16'h000C); wr_reg(8'h20, 16'h000C);
    @(negedge clk); irq = 13'h0080; idle(2); out_chk("R8", 3'd6, 8'h41);
    @(negedge clk); irq = 13'h0800; idle(2); out_chk("R8", 3'd3, 8'h52);
    @(negedge clk); irq = 13'h1000; idle(2); out_chk("R8", 3'd3, 8'h63);
    @(negedge clk); irq = 13'h0002; idle(2); out_chk("R8", 3'd2, 8'h0F);

    // R3: masking lets a lower rank win (source 4, ctrl 0x10)
    phase = "R3";
    @(negedge clk); irq = 13'h1FFF;
    wr_reg(8'h36, 16'h3FFE & ~16'h0010); idle(1); out_chk("R3", 3'd4, 8'h0F);
    wr_reg(8'h36, 16'h3FFE); idle(1); out_chk("R3", 3'd0, 8'h00);

    // R5: pseudo-random traffic compared every clock
    phase = "R5";
    lfsr = 16'hACE1;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      irq = lfsr[12:0] ^ lfsr[15:3];
      if (lfsr[3:0] == 4'h5) wr_reg(8'(8'h14 + (int'(lfsr[7:4]) % 13)), {8'h00, lfsr[15:8]});
      else if (lfsr[3:0] == 4'hA) wr_reg(8'h36, lfsr & 16'h2AAA);
    end
    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule